// File: doc/BRIEF.md
# Two-Stage Energy Timing Synchronizer

This block acquires symbol timing on an unmodulated pulse preamble for an energy-detection receiver. It sets a delay-offset code that positions the integration window of the front end. For each trial it adds up the energy samples that come back and keeps the offset that gave the most energy. The coarse search walks the offset across one symbol period in coarse steps. The fine search then walks one fine unit at a time across plus and minus one coarse step around the coarse winner.

Offsets are counted in fine units. One coarse step is `2**FINE_W` fine units, so the symbol period is `cfg_steps * 2**FINE_W` fine units. A controller pulses `start` once the channel shows preamble energy, so the coarse stage has to complete before the frame delimiter arrives. It then reads `coarse_off` and `fine_off` for demodulation and ranging. The coarse stage looks only at the upper `COARSE_W` bits of each sample. The fine stage uses the full `SMP_W` bits.

Top module: `esync_top`

## Requirements
- R1: After reset, `delay_code`, `coarse_off` and `fine_off` are 0 and both lock flags are low.
- R2: A `start` pulse captures `cfg_steps` (valid range 2 or more) and `cfg_pulses` (valid range 1 or more) and begins the coarse search. Coarse trial k drives `delay_code` = k*4 (default `FINE_W`=2), for k = 0 to `cfg_steps`-1, so every coarse offset has its two low bits at 0.
- R3: Each trial adds up exactly `cfg_pulses` accepted samples (`smp_vld` high). In the coarse stage a sample counts as `smp >> 1` (its upper 4 of 5 bits). In the fine stage it counts at its full 5-bit value.
- R4: The winning offset of a stage belongs to the trial with the largest sum. When sums are equal, the earlier trial wins.
- R5: At the end of the last coarse trial, `coarse_lock` is high for exactly one cycle. On that cycle `coarse_off` shows the coarse winner.
- R6: The fine search runs 9 trials (2*4+1). It starts at `coarse_off`-4 and steps by 1. Offsets wrap modulo the period `cfg_steps`*4, so a start below 0 becomes period-4 and an increment that reaches the period becomes 0.
- R7: At the end of the last fine trial, `fine_lock` is high for exactly one cycle and never on the same cycle as `coarse_lock`. On that cycle `fine_off` shows the fine winner, and `delay_code` then holds that value.
- R8: While no search is running, samples have no effect: `delay_code`, `coarse_off` and `fine_off` keep their values, and neither lock flag rises. The offsets change only on their own lock pulse.
- R9: `start` restarts the whole search at any time, even in the middle of a search. A sample presented on the same cycle as `start` is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin (or restart) the two-stage search |
| cfg_steps | input | STEP_W | Number of coarse trials per symbol period |
| cfg_pulses | input | PULSE_W | Samples added up per trial |
| smp_vld | input | 1 | Energy sample strobe |
| smp | input | SMP_W | Integrated energy sample from the converter |
| delay_code | output | STEP_W+FINE_W | Integration-window delay in fine units |
| coarse_lock | output | 1 | One-cycle pulse when the coarse stage completes |
| fine_lock | output | 1 | One-cycle pulse when the fine stage completes |
| coarse_off | output | STEP_W+FINE_W | Locked coarse offset |
| fine_off | output | STEP_W+FINE_W | Locked fine offset |

## Verification
Any corruption of the trial counter, the pulse counter or the offset stepper shows up on `delay_code` at the next sample boundary. The bench therefore compares `delay_code` with its own prediction before every sample it drives, so an error surfaces within one trial. A wrong running maximum, a wrong tie rule or a wrong sample truncation does not change the sequence of offsets. It shows only in the value of `coarse_off` or `fine_off` at the lock pulse. Flat, single-LSB and noisy peaked energy profiles expose it at the end of the stage concerned.

// File: rtl/esync_pkg.sv
package esync_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_COARSE = 2'd1,
    ST_FINE   = 2'd2
  } esync_state_e;
endpackage

// File: rtl/esync_rst_sync.sv
module esync_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/esync_trial_acc.sv
module esync_trial_acc #(
  parameter int SMP_W   = 5,
  parameter int PULSE_W = 4,
  parameter int ACC_W   = SMP_W + PULSE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               en,
  input  logic [SMP_W-1:0]   smp,
  input  logic [PULSE_W-1:0] lim,
  output logic               done,
  output logic [ACC_W-1:0]   sum
);
  logic [PULSE_W-1:0] cnt_q, cnt_d;
  logic [ACC_W-1:0]   acc_q, acc_d;

  assign sum  = acc_q + ACC_W'(smp);
  assign done = en && (cnt_q == lim - PULSE_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    acc_d = acc_q;
    if (clr || done) begin
      cnt_d = '0;
      acc_d = '0;
    end else if (en) begin
      cnt_d = cnt_q + PULSE_W'(1);
      acc_d = sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
    end
  end
endmodule

// File: rtl/esync_peak.sv
module esync_peak #(
  parameter int ACC_W = 9,
  parameter int OFF_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             first,
  input  logic [ACC_W-1:0] sum,
  input  logic [OFF_W-1:0] off,
  output logic [OFF_W-1:0] best_off_nxt
);
  logic [ACC_W-1:0] best_q;
  logic [OFF_W-1:0] boff_q;
  logic             win;

  // strict compare: an equal later sum never displaces the earlier offset
  assign win          = take && (first || (sum > best_q));
  assign best_off_nxt = win ? off : boff_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_q <= '0;
      boff_q <= '0;
    end else if (win) begin
      best_q <= sum;
      boff_q <= off;
    end
  end
endmodule

// File: rtl/esync_top.sv
module esync_top
  import esync_pkg::*;
#(
  parameter int SMP_W    = 5,
  parameter int COARSE_W = 4,
  parameter int STEP_W   = 5,
  parameter int FINE_W   = 2,
  parameter int PULSE_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [STEP_W-1:0]        cfg_steps,
  input  logic [PULSE_W-1:0]       cfg_pulses,
  input  logic                     smp_vld,
  input  logic [SMP_W-1:0]         smp,
  output logic [STEP_W+FINE_W-1:0] delay_code,
  output logic                     coarse_lock,
  output logic                     fine_lock,
  output logic [STEP_W+FINE_W-1:0] coarse_off,
  output logic [STEP_W+FINE_W-1:0] fine_off
);
  localparam int OFF_W       = STEP_W + FINE_W;
  localparam int ACC_W       = SMP_W + PULSE_W;
  localparam int FINE_TRIALS = 2 * (1 << FINE_W) + 1;
  localparam int TRIAL_W     = (STEP_W > FINE_W + 2) ? STEP_W : FINE_W + 2;
  localparam logic [OFF_W-1:0] STEP_OFF = OFF_W'(1 << FINE_W);

  logic rst_sn;
  esync_rst_sync u_rst (.clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_sn));

  esync_state_e       state_q, state_d;
  logic [OFF_W-1:0]   off_q, off_d, per_q, per_d, coff_q, coff_d, foff_q, foff_d;
  logic [OFF_W-1:0]   off_inc, fstart, best_nxt;
  logic [TRIAL_W-1:0] trial_q, trial_d;
  logic [STEP_W-1:0]  steps_q, steps_d;
  logic [PULSE_W-1:0] plim_q, plim_d;
  logic               clk_lock_q, clk_lock_d, flk_q, flk_d;
  logic               active, in_coarse, acc_en, trial_done, last_trial, first_trial;
  logic [SMP_W-1:0]   smp_sel;
  logic [ACC_W-1:0]   trial_sum;

  assign active      = (state_q != ST_IDLE);
  assign in_coarse   = (state_q == ST_COARSE);
  assign smp_sel     = in_coarse ? SMP_W'(smp >> (SMP_W - COARSE_W)) : smp;
  assign acc_en      = active && smp_vld && !start;
  assign first_trial = (trial_q == '0);
  assign last_trial  = in_coarse ? (trial_q == TRIAL_W'(steps_q) - TRIAL_W'(1))
                                 : (trial_q == TRIAL_W'(FINE_TRIALS - 1));

  esync_trial_acc #(.SMP_W(SMP_W), .PULSE_W(PULSE_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_sn), .clr(start), .en(acc_en), .smp(smp_sel),
    .lim(plim_q), .done(trial_done), .sum(trial_sum)
  );

  esync_peak #(.ACC_W(ACC_W), .OFF_W(OFF_W)) u_peak (
    .clk(clk), .rst_n(rst_sn), .take(trial_done), .first(first_trial),
    .sum(trial_sum), .off(off_q), .best_off_nxt(best_nxt)
  );

  // offset stepping: coarse grid, or fine unit wrapping at the symbol period
  always_comb begin
    if (in_coarse) begin
      off_inc = off_q + STEP_OFF;
    end else begin
      off_inc = off_q + OFF_W'(1);
      if (off_inc == per_q) off_inc = '0;
    end
    fstart = (best_nxt < STEP_OFF) ? (best_nxt + per_q - STEP_OFF) : (best_nxt - STEP_OFF);
  end

  always_comb begin
    state_d    = state_q;
    off_d      = off_q;
    trial_d    = trial_q;
    per_d      = per_q;
    steps_d    = steps_q;
    plim_d     = plim_q;
    coff_d     = coff_q;
    foff_d     = foff_q;
    clk_lock_d = 1'b0;
    flk_d      = 1'b0;
    if (start) begin
      state_d = ST_COARSE;
      off_d   = '0;
      trial_d = '0;
      steps_d = cfg_steps;
      plim_d  = cfg_pulses;
      per_d   = {cfg_steps, {FINE_W{1'b0}}};
    end else if (trial_done) begin
      if (!last_trial) begin
        trial_d = trial_q + TRIAL_W'(1);
        off_d   = off_inc;
      end else begin
        trial_d = '0;
        if (in_coarse) begin
          state_d    = ST_FINE;
          coff_d     = best_nxt;
          clk_lock_d = 1'b1;
          off_d      = fstart;
        end else begin
          state_d = ST_IDLE;
          foff_d  = best_nxt;
          flk_d   = 1'b1;
          off_d   = best_nxt;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q    <= ST_IDLE;
      off_q      <= '0;
      trial_q    <= '0;
      per_q      <= '0;
      steps_q    <= '0;
      plim_q     <= '0;
      coff_q     <= '0;
      foff_q     <= '0;
      clk_lock_q <= 1'b0;
      flk_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      off_q      <= off_d;
      trial_q    <= trial_d;
      per_q      <= per_d;
      steps_q    <= steps_d;
      plim_q     <= plim_d;
      coff_q     <= coff_d;
      foff_q     <= foff_d;
      clk_lock_q <= clk_lock_d;
      flk_q      <= flk_d;
    end
  end

  assign delay_code  = off_q;
  assign coarse_lock = clk_lock_q;
  assign fine_lock   = flk_q;
  assign coarse_off  = coff_q;
  assign fine_off    = foff_q;
endmodule

// File: rtl/esync_chk.sv
module esync_chk #(
  parameter int OFF_W  = 7,
  parameter int FINE_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             active,
  input logic [OFF_W-1:0] delay_code,
  input logic             coarse_lock,
  input logic             fine_lock,
  input logic [OFF_W-1:0] coarse_off,
  input logic [OFF_W-1:0] fine_off
);
  p_coarse_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    coarse_lock |=> !coarse_lock);

  p_fine_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fine_lock |=> !fine_lock);

  p_lock_apart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fine_lock |-> !coarse_lock);

  p_coarse_grid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    coarse_lock |-> (coarse_off[FINE_W-1:0] == '0));

  p_park_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fine_lock |=> (delay_code == $past(fine_off)));

  p_coarse_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !coarse_lock |-> $stable(coarse_off));

  p_fine_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fine_lock |-> $stable(fine_off));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !start) |=> $stable(delay_code));
endmodule

bind esync_top esync_chk #(.OFF_W(STEP_W + FINE_W), .FINE_W(FINE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .active(active),
  .delay_code(delay_code), .coarse_lock(coarse_lock), .fine_lock(fine_lock),
  .coarse_off(coarse_off), .fine_off(fine_off)
);

// File: tb/esync_top_tb_top.sv
module esync_top_tb_top;
  localparam int FPC = 4;
  localparam int FT  = 2 * FPC + 1;
  localparam int WD  = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [4:0] cfg_steps = '0;
  logic [3:0] cfg_pulses = '0;
  logic       smp_vld = 1'b0;
  logic [4:0] smp = '0;
  logic [6:0] delay_code, coarse_off, fine_off;
  logic       coarse_lock, fine_lock;

  int checks = 0, errors = 0, cyc = 0;
  int n_clk = 0, n_flk = 0;
  int exp_c = 0, exp_f = 0;
  int tgt = 0, nseed = 0, per = 8;

  always #10 clk = ~clk;

  esync_top dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_steps(cfg_steps),
    .cfg_pulses(cfg_pulses), .smp_vld(smp_vld), .smp(smp),
    .delay_code(delay_code), .coarse_lock(coarse_lock), .fine_lock(fine_lock),
    .coarse_off(coarse_off), .fine_off(fine_off)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int energy(input int mode, input int off, input int n);
    int d, e;
    if (mode == 1) return 9;
    if (mode == 2) return (off == FPC) ? 11 : 10;
    d = (off > tgt) ? off - tgt : tgt - off;
    if (per - d < d) d = per - d;
    e = 28 - 4 * d;
    if (e < 0) e = 0;
    e = e + ((off * 37 + n * 11 + nseed) % 4);
    if (e > 31) e = 31;
    return e;
  endfunction

  function automatic int fine_first(input int c);
    return (c < FPC) ? c + per - FPC : c - FPC;
  endfunction

  // expected winners from the requirement rules (R3, R4, R6)
  task automatic exp_search(input int steps, input int pulses, input int mode);
    int n, best, s, off;
    n = 0; best = 0;
    for (int k = 0; k < steps; k++) begin
      s = 0;
      for (int p = 0; p < pulses; p++) begin s += energy(mode, k * FPC, n) >> 1; n++; end
      if (k == 0 || s > best) begin best = s; exp_c = k * FPC; end
    end
    off = fine_first(exp_c);
    for (int j = 0; j < FT; j++) begin
      s = 0;
      for (int p = 0; p < pulses; p++) begin s += energy(mode, off, n); n++; end
      if (j == 0 || s > best) begin best = s; exp_f = off; end
      off = (off + 1 == per) ? 0 : off + 1;
    end
  endtask

  always @(negedge clk) begin
    if (coarse_lock) begin
      n_clk++;
      chk(coarse_off == exp_c, "R5 coarse_off at lock", coarse_off, exp_c);
    end
    if (fine_lock) begin
      n_flk++;
      chk(fine_off == exp_f, "R7 fine_off at lock", fine_off, exp_f);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD) begin
      errors++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run(input int steps, input int pulses, input int mode, input int abort);
    int total, t, expc;
    per = steps * FPC;
    exp_search(steps, pulses, mode);
    total = (steps + FT) * pulses;
    @(negedge clk);
    start = 1'b1; cfg_steps = 5'(steps); cfg_pulses = 4'(pulses);
    smp_vld = 1'b1; smp = 5'd31;  // R9: must not be counted
    @(negedge clk);
    start = 1'b0; smp_vld = 1'b0;
    n_clk = 0; n_flk = 0;
    for (int n = 0; n < total; n++) begin
      if (n == abort) return;
      t = n / pulses;
      expc = (t < steps) ? t * FPC : (fine_first(exp_c) + t - steps) % per;
      chk(delay_code == expc, (t < steps) ? "R2 coarse delay_code" : "R6 fine delay_code",
          delay_code, expc);
      smp_vld = 1'b1;
      smp = 5'(energy(mode, expc, n));
      @(negedge clk);
      smp_vld = 1'b0;
      repeat ($urandom % 3) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    chk(n_clk == 1, "R5 coarse_lock pulse count", n_clk, 1);
    chk(n_flk == 1, "R7 fine_lock pulse count", n_flk, 1);
    chk(coarse_off == exp_c, "R4 coarse winner", coarse_off, exp_c);
    chk(fine_off == exp_f, "R4 fine winner", fine_off, exp_f);
    chk(delay_code == exp_f, "R7 delay_code parks", delay_code, exp_f);
  endtask

  initial begin
    int hold_d, hold_c, hold_f;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(delay_code == 0, "R1 delay_code", delay_code, 0);
    chk(coarse_off == 0, "R1 coarse_off", coarse_off, 0);
    chk(fine_off == 0, "R1 fine_off", fine_off, 0);
    chk(coarse_lock == 0, "R1 coarse_lock", coarse_lock, 0);
    chk(fine_lock == 0, "R1 fine_lock", fine_lock, 0);

    // R4 ties + R6 wrap: flat profile, coarse 0, fine first trial = period-4
    run(4, 2, 1, -1);
    chk(fine_off == 12, "R6 wrap to period-4", fine_off, 12);
    // R3 coarse ignores the LSB, fine sees it
    run(3, 1, 2, -1);
    chk(coarse_off == 0, "R3 coarse truncation", coarse_off, 0);
    chk(fine_off == 4, "R3 fine full resolution", fine_off, 4);

    for (int i = 0; i < 10; i++) begin
      int st, pu;
      st = 2 + ($urandom % 11);
      pu = 1 + ($urandom % 6);
      per = st * FPC;
      tgt = $urandom % per;
      nseed = $urandom % 1000;
      run(st, pu, 0, -1);
    end

    // R9: abort in the fine stage, then a full run with other settings
    tgt = 5; nseed = 7; per = 5 * FPC;
    run(5, 3, 0, 5 * 3 + 4);
    tgt = 17; nseed = 3; per = 6 * FPC;
    run(6, 2, 0, -1);
    chk(coarse_off == exp_c, "R9 restart result", coarse_off, exp_c);

    // R8: samples while idle change nothing
    hold_d = delay_code; hold_c = coarse_off; hold_f = fine_off;
    n_clk = 0; n_flk = 0;
    for (int i = 0; i < 6; i++) begin
      smp_vld = 1'b1; smp = 5'($urandom % 32);
      @(negedge clk);
      smp_vld = 1'b0;
      @(negedge clk);
    end
    chk(delay_code == hold_d, "R8 idle delay_code", delay_code, hold_d);
    chk(coarse_off == hold_c, "R8 idle coarse_off", coarse_off, hold_c);
    chk(fine_off == hold_f, "R8 idle fine_off", fine_off, hold_f);
    chk(n_clk + n_flk == 0, "R8 idle lock pulses", n_clk + n_flk, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule